// File: doc/BRIEF.md
# Saturating Doubling Multiply-Subtract Vector Lane

This unit is a vector datapath stage. It takes two source vectors and an accumulator vector, each `VLEN` bits wide (128 by default). A 2-bit size input picks the wide element width. For every wide element position `e`, the unit reads narrow signed element `2*e` from each source. Narrow elements are half the wide width, so the unit uses only the even (bottom) narrow elements. It doubles the product of the two narrow elements and clamps the result to the signed wide range. It then subtracts that clamped product from accumulator element `e` and clamps the difference to the same range. All elements are updated, because there is no predicate.

An instruction word arrives with each operation. The unit checks the fixed opcode bits of that word. An operation is illegal if the opcode bits do not match or if the size code is reserved. An illegal operation is reported with a flag and passes the accumulator through unchanged.

Inputs are accepted on a cycle with `in_valid` high. The result appears one cycle later on the registered output stage, together with `out_valid`. A sticky saturation flag records that a clamp happened in any legal operation since reset.

Top module: `dms_vec_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `out_valid`, `illegal`, `sat` and `result` are all zero.
- R2: Inputs are sampled on a clock edge with `in_valid` high. `out_valid` is high for exactly the following cycle. While `in_valid` is low, `result` and `illegal` keep their values.
- R3: With size 01, `result` holds 16-bit elements. Element e is computed from the signed byte at bits [16e+7:16e] of each source and the signed 16-bit accumulator element at bits [16e+15:16e].
- R4: With size 10, `result` holds 32-bit elements. Element e is computed from the signed 16-bit value at bits [32e+15:32e] of each source and accumulator bits [32e+31:32e].
- R5: With size 11, `result` holds 64-bit elements. Element e is computed from the signed 32-bit value at bits [64e+31:64e] of each source and accumulator bits [64e+63:64e].
- R6: The doubled product 2*a*b is clamped to the range [-2^(W-1), 2^(W-1)-1], where W is the wide width. This clamp takes effect only when both narrow inputs are the most negative value; in that case the product becomes 2^(W-1)-1.
- R7: Each result element equals accumulator element minus the clamped product, clamped to [-2^(W-1), 2^(W-1)-1].
- R8: Size 00 is reserved. It gives `illegal`=1 and `result` equal to the accumulator, and it leaves `sat` unchanged.
- R9: The instruction word is legal only when bits [31:24]=8'h44, bit 21=0 and bits [15:10]=6'b011010. Any other value gives `illegal`=1 and `result` equal to the accumulator. Bits [23:22], [20:16] and [9:0] are not checked; the element width comes only from the `size` input.
- R10: `sat` becomes 1 after a legal operation in which either clamp changed a value in any element. It then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation accepted on this edge |
| insn | input | 32 | Instruction word checked for the opcode pattern |
| size | input | 2 | Element size code (01/10/11 legal, 00 reserved) |
| src_a | input | VLEN | First source vector |
| src_b | input | VLEN | Second source vector |
| acc | input | VLEN | Accumulator vector |
| out_valid | output | 1 | Result valid, one cycle after acceptance |
| result | output | VLEN | New accumulator value |
| illegal | output | 1 | Registered illegal-operation flag |
| sat | output | 1 | Sticky saturation flag |

## Verification
The product clamp is the hardest case to reach. It happens only when both narrow inputs in an even slot hold the most negative value, and uniform random operands almost never produce that. The stimulus therefore places that pattern in every even slot at each of the three sizes. It also mixes random vectors in which each narrow element is replaced by an extreme value with high probability. The difference clamp is driven in both directions by pairing an extreme accumulator with a product of the opposite sign.

// File: rtl/dms_pkg.sv
// Shared constants and types for the doubling multiply-subtract unit.
// Assumes a 32-bit instruction word whose fixed bits are given by a mask and a match value.
package dms_pkg;
    typedef enum logic [1:0] {
        SZ_RSV = 2'b00,
        SZ_H   = 2'b01,
        SZ_S   = 2'b10,
        SZ_D   = 2'b11
    } dms_size_e;

    localparam logic [31:0] OPC_MASK  = 32'hFF20_FC00;
    localparam logic [31:0] OPC_MATCH = 32'h4400_6800;
endpackage

// File: rtl/dms_decode.sv
// Opcode check: the operation is legal when the fixed opcode bits match
// and the size code is not the reserved value. Purely combinational.
module dms_decode
    import dms_pkg::*;
(
    input  logic [31:0] insn,
    input  logic [1:0]  size,
    output logic        legal
);
    // Compare fixed fields and reject the reserved size
    always_comb begin
        legal = ((insn & OPC_MASK) == OPC_MATCH) && (size != SZ_RSV);
    end
endmodule

// File: rtl/dms_elem.sv
// One wide element: doubled signed product of two narrow values, clamped,
// then subtracted from the accumulator element and clamped again.
// Assumes EW is even; narrow inputs are EW/2 bits, two's complement.
module dms_elem #(
    parameter int EW = 16
) (
    input  logic [EW/2-1:0] a,
    input  logic [EW/2-1:0] b,
    input  logic [EW-1:0]   c,
    output logic [EW-1:0]   r,
    output logic            clamp
);
    localparam int HW = EW / 2;
    localparam logic [EW-1:0] MAXV = {1'b0, {(EW-1){1'b1}}};
    localparam logic [EW-1:0] MINV = {1'b1, {(EW-1){1'b0}}};

    logic signed [EW:0]   ax, bx, prod, diff;
    logic        [EW-1:0] psat;
    logic                 pclamp, dclamp;

    // Sign-extend the narrow inputs and form the doubled product
    always_comb begin
        ax   = $signed({{(HW+1){a[HW-1]}}, a});
        bx   = $signed({{(HW+1){b[HW-1]}}, b});
        prod = (ax * bx) <<< 1;
    end

    // Clamp the product to the wide range
    always_comb begin
        pclamp = prod[EW] != prod[EW-1];
        if (!pclamp)      psat = prod[EW-1:0];
        else if (prod[EW]) psat = MINV;
        else              psat = MAXV;
    end

    // Subtract from the accumulator and clamp the difference
    always_comb begin
        diff   = $signed({c[EW-1], c}) - $signed({psat[EW-1], psat});
        dclamp = diff[EW] != diff[EW-1];
        if (!dclamp)      r = diff[EW-1:0];
        else if (diff[EW]) r = MINV;
        else              r = MAXV;
        clamp  = pclamp | dclamp;
    end
endmodule

// File: rtl/dms_group.sv
// All elements of one width across the vector. Element e reads the bottom
// narrow slot of each EW-bit chunk. Assumes VLEN is a multiple of EW.
module dms_group #(
    parameter int VLEN = 128,
    parameter int EW   = 16
) (
    input  logic [VLEN-1:0] src_a,
    input  logic [VLEN-1:0] src_b,
    input  logic [VLEN-1:0] acc,
    output logic [VLEN-1:0] res,
    output logic            clamp_any
);
    localparam int NE = VLEN / EW;
    localparam int HW = EW / 2;

    logic [NE-1:0] clamp_e;

    for (genvar e = 0; e < NE; e++) begin : g_el
        dms_elem #(.EW(EW)) u_elem (
            .a     (src_a[e*EW +: HW]),
            .b     (src_b[e*EW +: HW]),
            .c     (acc[e*EW +: EW]),
            .r     (res[e*EW +: EW]),
            .clamp (clamp_e[e])
        );
    end

    // Any element clamped in this width group
    always_comb clamp_any = |clamp_e;
endmodule

// File: rtl/dms_vec_unit.sv
// Top: saturating doubling multiply-subtract over a VLEN-bit vector.
// Computes all three widths in parallel, selects by size, and registers the
// result one cycle after in_valid. Illegal operations pass acc through.
// Synchronous active-low reset; VLEN must be a multiple of 64.
module dms_vec_unit
    import dms_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     insn,
    input  logic [1:0]      size,
    input  logic [VLEN-1:0] src_a,
    input  logic [VLEN-1:0] src_b,
    input  logic [VLEN-1:0] acc,
    output logic            out_valid,
    output logic [VLEN-1:0] result,
    output logic            illegal,
    output logic            sat
);
    localparam int NW = 3;

    logic            legal;
    logic [VLEN-1:0] grp_res [NW];
    logic [NW-1:0]   grp_clamp;
    logic [VLEN-1:0] sel_res;
    logic            sel_clamp;

    dms_decode u_dec (
        .insn  (insn),
        .size  (size),
        .legal (legal)
    );

    for (genvar w = 0; w < NW; w++) begin : g_w
        dms_group #(.VLEN(VLEN), .EW(16 << w)) u_grp (
            .src_a     (src_a),
            .src_b     (src_b),
            .acc       (acc),
            .res       (grp_res[w]),
            .clamp_any (grp_clamp[w])
        );
    end

    // Pick the width group named by size; illegal operations pass acc
    always_comb begin
        sel_res   = acc;
        sel_clamp = 1'b0;
        if (legal) begin
            case (size)
                SZ_H:    begin sel_res = grp_res[0]; sel_clamp = grp_clamp[0]; end
                SZ_S:    begin sel_res = grp_res[1]; sel_clamp = grp_clamp[1]; end
                default: begin sel_res = grp_res[2]; sel_clamp = grp_clamp[2]; end
            endcase
        end
    end

    // Output register stage with sticky saturation flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            illegal   <= 1'b0;
            sat       <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= sel_res;
                illegal <= !legal;
                sat     <= sat | sel_clamp;
            end
        end
    end
endmodule

// File: rtl/dms_vec_unit_chk.sv
// Checker for dms_vec_unit, attached by bind. Relates port behaviour over time.
module dms_vec_unit_chk #(
    parameter int VLEN = 128
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [1:0]      size,
    input logic [VLEN-1:0] acc,
    input logic            out_valid,
    input logic [VLEN-1:0] result,
    input logic            illegal,
    input logic            sat
);
    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(result) && $stable(illegal));

    // R8
    reserved_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size == 2'b00) |=> illegal && result == $past(acc) && sat == $past(sat));

    // R10
    sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sat |=> sat);

    // R10
    sat_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat) |-> $past(in_valid) && !illegal);
endmodule

bind dms_vec_unit dms_vec_unit_chk #(.VLEN(VLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .size      (size),
    .acc       (acc),
    .out_valid (out_valid),
    .result    (result),
    .illegal   (illegal),
    .sat       (sat)
);

// File: tb/dms_vec_unit_tb.sv
// Self-checking bench: directed corners plus seeded random against a wide-integer model.
module dms_vec_unit_tb;
    localparam int VL      = 128;
    localparam int CLK_PER = 10;
    localparam logic [31:0] GOOD = 32'h4400_6800;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [31:0]   insn = GOOD;
    logic [1:0]    size = 2'b01;
    logic [VL-1:0] src_a = '0, src_b = '0, acc = '0;
    logic          out_valid, illegal, sat;
    logic [VL-1:0] result;

    int  errors = 0;
    int  checks = 0;
    bit  exp_sat = 1'b0;
    bit  done = 1'b0;
    int unsigned seed_dummy;

    always #(CLK_PER/2) clk = ~clk;

    dms_vec_unit #(.VLEN(VL)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .size(size),
        .src_a(src_a), .src_b(src_b), .acc(acc),
        .out_valid(out_valid), .result(result), .illegal(illegal), .sat(sat)
    );

    task automatic chk(input string req, input logic [VL-1:0] act, input logic [VL-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference: wide signed arithmetic with explicit clamping
    function automatic void model(input logic [1:0] sz, input logic [VL-1:0] a, b, c,
                                  output logic [VL-1:0] r, output bit clamp);
        int ew, hw, ne;
        logic signed [130:0] one, hi, lo, va, vb, vc, p, d;
        ew = 8 << sz; hw = ew / 2; ne = VL / ew;
        one = 1; hi = (one <<< (ew-1)) - 1; lo = -(one <<< (ew-1));
        r = '0; clamp = 1'b0;
        for (int e = 0; e < ne; e++) begin
            for (int k = 0; k < 131; k++) begin
                va[k] = (k < hw) ? a[e*ew+k] : a[e*ew+hw-1];
                vb[k] = (k < hw) ? b[e*ew+k] : b[e*ew+hw-1];
                vc[k] = (k < ew) ? c[e*ew+k] : c[e*ew+ew-1];
            end
            p = 2 * va * vb;
            if (p > hi) begin p = hi; clamp = 1'b1; end
            if (p < lo) begin p = lo; clamp = 1'b1; end
            d = vc - p;
            if (d > hi) begin d = hi; clamp = 1'b1; end
            if (d < lo) begin d = lo; clamp = 1'b1; end
            for (int k = 0; k < ew; k++) r[e*ew+k] = d[k];
        end
    endfunction

    // Issue one operation and check it one cycle later
    task automatic op(input string req, input logic [31:0] iw, input logic [1:0] sz,
                      input logic [VL-1:0] a, b, c);
        logic [VL-1:0] er;
        bit cl, ok;
        ok = ((iw & 32'hFF20_FC00) == GOOD) && (sz != 2'b00);
        if (ok) model(sz, a, b, c, er, cl);
        else begin er = c; cl = 1'b0; end
        @(negedge clk);
        insn = iw; size = sz; src_a = a; src_b = b; acc = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        if (cl) exp_sat = 1'b1;
        chk({req, " result"}, result, er);
        chk({req, " out_valid R2"}, VL'(out_valid), VL'(1));
        chk({req, " illegal"}, VL'(illegal), VL'(!ok));
        chk({req, " sat R10"}, VL'(sat), VL'(exp_sat));
    endtask

    // Vector with each narrow slot filled from a pattern per width
    function automatic logic [VL-1:0] fill(input int hw, input logic [63:0] v);
        logic [VL-1:0] x = '0;
        for (int i = 0; i < VL / hw; i++)
            for (int k = 0; k < hw; k++) x[i*hw+k] = v[k];
        return x;
    endfunction

    // Random vector, narrow slots often forced to extremes
    function automatic logic [VL-1:0] rvec(input int hw);
        logic [VL-1:0] x;
        for (int i = 0; i < VL / 32; i++) x[i*32 +: 32] = $urandom;
        for (int i = 0; i < VL / hw; i++) begin
            int u = $urandom_range(0, 3);
            if (u == 0) for (int k = 0; k < hw; k++) x[i*hw+k] = (k == hw-1);
            if (u == 1) for (int k = 0; k < hw; k++) x[i*hw+k] = (k != hw-1);
        end
        return x;
    endfunction

    initial begin
        #(CLK_PER * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [VL-1:0] a, b, c;
        seed_dummy = $urandom(32'd12345);
        repeat (3) @(negedge clk);
        chk("R1 reset out_valid", VL'(out_valid), '0);
        chk("R1 reset result", result, '0);
        chk("R1 reset flags", VL'({illegal, sat}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", VL'({out_valid, illegal, sat}), '0);

        // Non-clamping ops leave sat clear
        op("R3 small", GOOD, 2'b01, fill(8, 64'h03), fill(8, 64'hFE), fill(16, 64'h0010));
        op("R4 small", GOOD | 32'h001F_03FF, 2'b10, fill(16, 64'h1234), fill(16, 64'h0002), fill(32, 64'h7));
        op("R5 small", GOOD, 2'b11, fill(32, 64'hFFFF_FFFF), fill(32, 64'h5), fill(64, 64'h100));
        op("R9 bad top byte", 32'h4500_6800, 2'b01, fill(8, 64'h80), fill(8, 64'h80), fill(16, 64'h1357));
        op("R9 bit21 set", GOOD | 32'h0020_0000, 2'b10, fill(8, 64'h80), fill(8, 64'h80), fill(16, 64'h2468));
        op("R9 bad low opcode", GOOD ^ 32'h0000_0400, 2'b11, fill(8, 64'h80), fill(8, 64'h80), fill(16, 64'hABCD));
        op("R8 reserved size", GOOD, 2'b00, fill(8, 64'h80), fill(8, 64'h80), fill(16, 64'h8000));

        // Idle cycle holds result
        a = result;
        @(negedge clk);
        chk("R2 hold result", result, a);
        chk("R2 out_valid low", VL'(out_valid), '0);

        // Product clamp at every size, then difference clamp both ways
        op("R6 R3 min*min", GOOD, 2'b01, fill(8, 64'h80), fill(8, 64'h80), fill(16, 64'h0000));
        op("R6 R4 min*min", GOOD, 2'b10, fill(16, 64'h8000), fill(16, 64'h8000), fill(32, 64'h8000_0000));
        op("R6 R5 min*min", GOOD, 2'b11, fill(32, 64'h8000_0000), fill(32, 64'h8000_0000), fill(64, 64'h1));
        op("R7 overflow", GOOD, 2'b01, fill(8, 64'h80), fill(8, 64'h7F), fill(16, 64'h7FFF));
        op("R7 underflow", GOOD, 2'b11, fill(32, 64'h7FFF_FFFF), fill(32, 64'h7FFF_FFFF), fill(64, 64'h8000_0000_0000_0000));
        op("R10 stays set", GOOD, 2'b10, '0, '0, fill(32, 64'h5));
        op("R8 reserved keeps sat", GOOD, 2'b00, '0, '0, fill(32, 64'h9));

        // Seeded random at all legal sizes
        for (int n = 0; n < 300; n++) begin
            logic [1:0] sz;
            int hw;
            sz = 2'($urandom_range(1, 3));
            hw = 4 << sz;
            a = rvec(hw); b = rvec(hw); c = rvec(2*hw);
            op("R3 R4 R5 R7 random", GOOD | ($urandom & ~32'hFF20_FC00), sz, a, b, c);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule